// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is a synchronous command interpreter for a byte-wide parallel flash of 512K bytes. Bus writes arrive as single-cycle strobes with an address and a data byte. The controller matches them against multi-write command sequences:

- byte program;
- page, sector and whole-array erase;
- entry to and exit from an identification mode;
- a one-time boot region lockout.

Bus reads return one of three things: array contents, identifier bytes, or a status byte while an operation is running.

The storage itself sits outside the block, behind a combinational read port, a byte write port and a range-clear port. The array holds eight 64 KB sectors, and each sector holds sixteen 4 KB pages. Program and erase run for a set number of clocks per operation type, and the array is committed in the last busy cycle. A boot region of 16K or 64K, at either the top or the bottom of the address space, can be locked. Once locked, program and erase aimed at that region are rejected.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Out of reset the controller is in read mode with no lockout. A read returns `mem_rdata` for `bus_addr`.
- R2: Byte program is four writes: 0xAA@0x05555, 0x55@0x02AAA, 0xA0@0x05555, then data@target. The stored byte becomes the AND of the old byte and the new data.
- R3: A write that does not continue a valid sequence (wrong address or data) abandons the sequence, starts no operation and returns to read mode. This includes leaving identification mode.
- R4: Erase is 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, then one final write with one of three codes:
  - 0x30@addr clears the sector addr[18:16];
  - 0x50@addr clears the page addr[18:12];
  - 0x10@0x05555 clears the whole array.
  Every byte of the cleared range reads 0xFF.
- R5: While busy, a read returns a status byte:
  - bit 7 is the complement of bit 7 of the programmed data, or 0 for an erase;
  - bit 6 starts at 0 and flips after each read strobe;
  - bits 5:0 are 0.
  Busy lasts T_PROG, T_PAGE, T_SECT or T_CHIP clocks. The controller then returns to read mode.
- R6: Writes that arrive while busy are ignored.
- R7: The unlock pair followed by 0x90@0x05555 enters identification mode. In this mode, reads with addr[1:0]=0 return 0xDA and reads with addr[1:0]=1 return 0xB6. Both values have odd parity.
- R8: Identification mode is left by a single 0xF0 write at any address, or by the unlock pair followed by 0xF0@0x05555.
- R9: The unlock pair followed by 0x40@0x05555 sets up a lockout. The next write then sets the lockout:
  - data 0x02 selects a 16K region and data 0x03 selects a 64K region;
  - address bit 18 high selects the top region, low selects the bottom region.
  The top regions are 0x7C000 or 0x70000 up to 0x7FFFF. The bottom regions are 0x00000 up to 0x03FFF or 0x0FFFF. Once set, the lockout ignores further lockout commands until reset.
- R10: A program inside the locked region, or an erase whose range overlaps it, starts nothing and changes no byte. Other addresses stay writable.
- R11: In identification mode, the lockout code is read as bits 1:0 (0b10 for 16K, 0b11 for 64K):
  - at 0x00002 when a bottom region is locked;
  - at 0x7FFF2 when a top region is locked.
  Each of these addresses reads 0x00 when no region is locked there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_re | input | 1 | Bus read strobe, advances the status toggle |
| bus_addr | input | 19 | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data: array, identifier or status |
| mem_raddr | output | 19 | Array read address |
| mem_rdata | input | 8 | Array read data, combinational |
| mem_we | output | 1 | Array byte write strobe |
| mem_waddr | output | 19 | Array write address |
| mem_wdata | output | 8 | Array write data |
| mem_clr | output | 1 | Set a range of the array to 0xFF |
| mem_clr_lo | output | 19 | First address of the cleared range |
| mem_clr_hi | output | 19 | Last address of the cleared range |

## Verification
Two events can fall in the same clock. The first is the end of a busy period, where the array commit takes place. The second is a new bus write or read strobe. The bench provokes this by issuing back-to-back unlock writes and reads straight across the last busy cycle. A reference model kept as a queue of pending writes judges, cycle by cycle, which of those writes must be dropped and which must start a new sequence, and whether the status toggle or the array data must appear on the bus.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int T_PROG = 6,
  parameter int T_PAGE = 10,
  parameter int T_SECT = 14,
  parameter int T_CHIP = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [18:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [18:0] mem_raddr,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic [18:0] mem_waddr,
  output logic [7:0]  mem_wdata,
  output logic        mem_clr,
  output logic [18:0] mem_clr_lo,
  output logic [18:0] mem_clr_hi
);

  localparam int TM1  = (T_PROG > T_PAGE) ? T_PROG : T_PAGE;
  localparam int TM2  = (T_SECT > T_CHIP) ? T_SECT : T_CHIP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [3:0] {IDLE, U1, U2, PSET, E1, E2, E3, LSET, BUSY} st_t;

  st_t         st;
  logic        id_mode, lk_top, op_prog, tog;
  logic [1:0]  lk;
  logic [CW-1:0] cnt;
  logic [18:0] op_lo, op_hi;
  logic [7:0]  op_data;

  wire busy    = (st == BUSY);
  wire done    = busy && (cnt == '0);
  wire a5555   = (bus_addr == 19'h05555);
  wire a2aaa   = (bus_addr == 19'h02AAA);
  wire unlock1 = a5555 && (bus_wdata == 8'hAA);
  wire unlock2 = a2aaa && (bus_wdata == 8'h55);

  wire [18:0] lk_lo = lk_top ? (lk[0] ? 19'h70000 : 19'h7C000) : 19'h00000;
  wire [18:0] lk_hi = lk_top ? 19'h7FFFF : (lk[0] ? 19'h0FFFF : 19'h03FFF);

  function automatic logic hits(input logic [18:0] lo, input logic [18:0] hi);
    return lk[1] && (lo <= lk_hi) && (hi >= lk_lo);
  endfunction

  logic [18:0]   ers_lo, ers_hi;
  logic          ers_ok;
  logic [CW-1:0] ers_t;
  always_comb begin
    ers_ok = 1'b1;
    ers_lo = '0;
    ers_hi = 19'h7FFFF;
    ers_t  = CW'(T_CHIP - 1);
    case (bus_wdata)
      8'h10: ers_ok = a5555;
      8'h30: begin
        ers_lo = {bus_addr[18:16], 16'h0000};
        ers_hi = {bus_addr[18:16], 16'hFFFF};
        ers_t  = CW'(T_SECT - 1);
      end
      8'h50: begin
        ers_lo = {bus_addr[18:12], 12'h000};
        ers_hi = {bus_addr[18:12], 12'hFFF};
        ers_t  = CW'(T_PAGE - 1);
      end
      default: ers_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; id_mode <= 1'b0; lk <= 2'b00; lk_top <= 1'b0;
      cnt <= '0; op_prog <= 1'b0; op_lo <= '0; op_hi <= '0;
      op_data <= '0; tog <= 1'b0;
    end else if (busy) begin
      if (bus_re) tog <= ~tog;
      if (done) begin
        st <= IDLE;
        id_mode <= 1'b0;
      end else cnt <= cnt - 1'b1;
    end else if (bus_we) begin
      st <= IDLE;
      id_mode <= 1'b0;
      case (st)
        IDLE: if (unlock1) begin st <= U1; id_mode <= id_mode; end
        U1:   if (unlock2) begin st <= U2; id_mode <= id_mode; end
        U2: if (a5555) begin
          id_mode <= id_mode;
          case (bus_wdata)
            8'hA0:   st <= PSET;
            8'h80:   st <= E1;
            8'h40:   st <= LSET;
            8'h90:   id_mode <= 1'b1;
            default: id_mode <= 1'b0;
          endcase
        end
        PSET: if (!hits(bus_addr, bus_addr)) begin
          st <= BUSY; cnt <= CW'(T_PROG - 1); op_prog <= 1'b1;
          op_lo <= bus_addr; op_hi <= bus_addr; op_data <= bus_wdata; tog <= 1'b0;
        end
        E1: if (unlock1) begin st <= E2; id_mode <= id_mode; end
        E2: if (unlock2) begin st <= E3; id_mode <= id_mode; end
        E3: if (ers_ok && !hits(ers_lo, ers_hi)) begin
          st <= BUSY; cnt <= ers_t; op_prog <= 1'b0;
          op_lo <= ers_lo; op_hi <= ers_hi; op_data <= 8'h00; tog <= 1'b0;
        end
        LSET: if (!lk[1] && bus_wdata[7:1] == 7'b0000001) begin
          lk <= bus_wdata[1:0];
          lk_top <= bus_addr[18];
        end
        default: ;
      endcase
    end
  end

  logic [7:0] id_data;
  always_comb begin
    case (bus_addr[1:0])
      2'd0: id_data = 8'hDA;
      2'd1: id_data = 8'hB6;
      2'd2: id_data = (lk[1] && ((lk_top && bus_addr == 19'h7FFF2) ||
                       (!lk_top && bus_addr == 19'h00002))) ? {6'b0, lk} : 8'h00;
      default: id_data = 8'h00;
    endcase
  end

  assign bus_rdata  = busy ? {op_prog & ~op_data[7], tog, 6'b0} :
                      id_mode ? id_data : mem_rdata;
  assign mem_raddr  = busy ? op_lo : bus_addr;
  assign mem_we     = done && op_prog;
  assign mem_waddr  = op_lo;
  assign mem_wdata  = mem_rdata & op_data;
  assign mem_clr    = done && !op_prog;
  assign mem_clr_lo = op_lo;
  assign mem_clr_hi = op_hi;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        bus_re,
  input logic [7:0]  bus_rdata,
  input logic        mem_we,
  input logic [18:0] mem_waddr,
  input logic        mem_clr,
  input logic [1:0]  lk,
  input logic        lk_top
);

  wire [18:0] rlo = lk_top ? (lk[0] ? 19'h70000 : 19'h7C000) : 19'h00000;
  wire [18:0] rhi = lk_top ? 19'h7FFFF : (lk[0] ? 19'h0FFFF : 19'h03FFF);

  // R2 R4
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_clr}));

  // R10
  lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(lk[1] && mem_waddr >= rlo && mem_waddr <= rhi));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_clr) |=> !busy);

  // R5
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(bus_re)) |-> (bus_rdata[6] != $past(bus_rdata[6])));

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk[1] |=> ($stable(lk) && $stable(lk_top)));

endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_clr(mem_clr), .lk(lk), .lk_top(lk_top)
);

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
  localparam int TP = 6, TG = 10, TS = 14, TC = 20;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_re = 0;
  logic [18:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, mem_rdata, mem_wdata;
  logic [18:0] mem_raddr, mem_waddr, mem_clr_lo, mem_clr_hi;
  logic mem_we, mem_clr;

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.T_PROG(TP), .T_PAGE(TG), .T_SECT(TS), .T_CHIP(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_clr(mem_clr), .mem_clr_lo(mem_clr_lo),
    .mem_clr_hi(mem_clr_hi));

  // behavioural storage seen by the design
  logic [7:0] dmem [int];
  int mem_upd = 0;
  always @(mem_raddr or mem_upd)
    mem_rdata = dmem.exists(int'(mem_raddr)) ? dmem[int'(mem_raddr)] : 8'hFF;
  always @(posedge clk) begin
    if (mem_we) begin dmem[int'(mem_waddr)] = mem_wdata; mem_upd++; end
    if (mem_clr) begin
      int kill[$];
      foreach (dmem[k]) if (k >= int'(mem_clr_lo) && k <= int'(mem_clr_hi)) kill.push_back(k);
      foreach (kill[i]) dmem.delete(kill[i]);
      mem_upd++;
    end
  end

  // reference model
  int  q_a[$], q_d[$];
  bit  m_id, m_top, m_prog, m_tog;
  int  m_lk, m_busy, m_lo, m_hi, m_d;
  logic [7:0] mm [int];

  function automatic int mget(int a);
    return mm.exists(a) ? int'(mm[a]) : 255;
  endfunction

  function automatic bit locked(int lo, int hi);
    int rl, rh;
    if (m_lk == 0) return 0;
    if (m_top) begin rl = (m_lk == 3) ? 'h70000 : 'h7C000; rh = 'h7FFFF; end
    else begin rl = 0; rh = (m_lk == 3) ? 'h0FFFF : 'h03FFF; end
    return !(hi < rl || lo > rh);
  endfunction

  function automatic int expect_rd(int a);
    if (m_busy > 0) return ((m_prog && !m_d[7]) ? 128 : 0) + (m_tog ? 64 : 0);
    if (m_id) begin
      case (a & 3)
        0: return 'hDA;
        1: return 'hB6;
        2: if (m_lk != 0 && ((m_top && a == 'h7FFF2) || (!m_top && a == 2))) return m_lk;
           else return 0;
        default: return 0;
      endcase
    end
    return mget(a);
  endfunction

  task automatic start_busy(int t, bit p, int lo, int hi, int d);
    m_busy = t; m_prog = p; m_lo = lo; m_hi = hi; m_d = d; m_tog = 0;
  endtask

  task automatic resolve(bit id);
    q_a.delete(); q_d.delete(); m_id = id;
  endtask

  task automatic model_write(int a, int d);
    int n;
    q_a.push_back(a); q_d.push_back(d);
    n = q_a.size();
    if (n == 1 || n == 4 && q_d[2] == 'h80) begin
      if (!(a == 'h5555 && d == 'hAA)) resolve(0);
    end else if (n == 2 || n == 5) begin
      if (!(a == 'h2AAA && d == 'h55)) resolve(0);
    end else if (n == 3) begin
      if (a != 'h5555) resolve(0);
      else if (d == 'h90) resolve(1);
      else if (!(d == 'hA0 || d == 'h80 || d == 'h40)) resolve(0);
    end else if (n == 4 && q_d[2] == 'hA0) begin
      if (!locked(a, a)) start_busy(TP, 1, a, a, d);
      resolve(0);
    end else if (n == 4) begin
      if (m_lk == 0 && (d == 2 || d == 3)) begin m_lk = d; m_top = a[18]; end
      resolve(0);
    end else begin
      int lo, hi, t; bit ok;
      ok = 1;
      if (d == 'h10 && a == 'h5555) begin lo = 0; hi = 'h7FFFF; t = TC; end
      else if (d == 'h30) begin lo = a & 'h70000; hi = lo + 'hFFFF; t = TS; end
      else if (d == 'h50) begin lo = a & 'h7F000; hi = lo + 'hFFF; t = TG; end
      else begin ok = 0; lo = 0; hi = 0; t = 0; end
      if (ok && !locked(lo, hi)) start_busy(t, 0, lo, hi, 0);
      resolve(0);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q_a.delete(); q_d.delete();
      m_id = 0; m_top = 0; m_prog = 0; m_tog = 0; m_lk = 0; m_busy = 0;
    end else if (m_busy > 0) begin
      if (bus_re) m_tog = !m_tog;
      m_busy--;
      if (m_busy == 0) begin
        if (m_prog) mm[m_lo] = 8'(mget(m_lo) & m_d);
        else begin
          int kill[$];
          foreach (mm[k]) if (k >= m_lo && k <= m_hi) kill.push_back(k);
          foreach (kill[i]) mm.delete(kill[i]);
        end
        m_id = 0;
      end
    end else if (bus_we) model_write(int'(bus_addr), int'(bus_wdata));
  end

  // comparison on every clock
  int nvec = 0, nbad = 0, cyc = 0;
  string cur_req = "R1";
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int e;
      e = expect_rd(int'(bus_addr));
      nvec++;
      if (int'(bus_rdata) != e) begin
        nbad++;
        $display("FAIL %s addr=%05h actual=%02h expected=%02h", cur_req, bus_addr, bus_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    bus_we = 1; bus_addr = a[18:0]; bus_wdata = d[7:0];
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(int a);
    bus_re = 1; bus_addr = a[18:0];
    @(negedge clk); bus_re = 0;
  endtask
  task automatic cmd(int c);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, c);
  endtask
  task automatic prog(int a, int d);
    cmd('hA0); wr(a, d);
  endtask
  task automatic erase(int code, int a);
    cmd('h80); wr('h5555, 'hAA); wr('h2AAA, 'h55); wr(a, code);
  endtask
  task automatic poll(int n, int a);
    repeat (n) rd(a);
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1 reset state: read mode, erased array
    cur_req = "R1"; rd('h00000); rd('h12345); rd('h7FFFF);
    // R2 program and AND behaviour, R5 status while busy
    cur_req = "R2"; prog('h12345, 'h5A);
    cur_req = "R5"; poll(TP + 2, 'h12345);
    cur_req = "R2"; prog('h12345, 'h0F); poll(TP + 1, 'h12345); rd('h12345);
    prog('h00010, 'hFE); poll(TP + 1, 'h00010);
    // R6 writes across the busy window and its last cycle
    cur_req = "R6"; prog('h20000, 'h33);
    repeat (3) begin wr('h5555, 'hAA); wr('h2AAA, 'h55); end
    wr('h5555, 'hA0); wr('h20000, 'h00);
    poll(4, 'h20000); rd('h20000);
    // R3 broken sequences
    cur_req = "R3"; wr('h5555, 'hAA); wr('h1234, 'h55); wr('h5555, 'hA0); wr('h30000, 'h00);
    poll(TP + 1, 'h30000);
    wr('h5555, 'hAA); wr('h2AAA, 'h55); wr('h5555, 'h77); wr('h30001, 'h00); rd('h30001);
    // R7 identification, R8 both exits
    cur_req = "R7"; cmd('h90); rd('h00000); rd('h00001); rd('h45601); rd('h12345);
    cur_req = "R8"; wr('h3333, 'hF0); rd('h00000); rd('h12345);
    cur_req = "R7"; cmd('h90); rd('h00100);
    cur_req = "R8"; cmd('hF0); rd('h00100); rd('h12345);
    cur_req = "R3"; cmd('h90); rd('h00001); wr('h5555, 'h12); rd('h00001);
    // R11 no lockout: status addresses read zero
    cur_req = "R11"; cmd('h90); rd('h00002); rd('h7FFF2); wr('h0, 'hF0);
    // R4 page, sector, chip erase
    cur_req = "R4"; prog('h41000, 'h11); poll(TP, 'h41000);
    prog('h42000, 'h22); poll(TP, 'h42000);
    erase('h50, 'h41ABC); poll(TG + 1, 'h41000); rd('h41000); rd('h42000);
    cur_req = "R5"; erase('h30, 'h12000); poll(TS + 1, 'h12345); rd('h12345); rd('h20000);
    cur_req = "R4"; erase('h10, 'h1234); rd('h00010);
    erase('h10, 'h5555); poll(TC + 1, 'h00010); rd('h00010); rd('h42000);
    // R9 bottom 16K lockout, R10 guarded region, R11 status
    cur_req = "R9"; cmd('h40); wr('h00000, 'h02);
    cur_req = "R11"; cmd('h90); rd('h00002); rd('h7FFF2); rd('h10002); wr('h0, 'hF0);
    cur_req = "R10"; prog('h01000, 'h00); poll(3, 'h01000);
    prog('h04000, 'h44); poll(TP + 1, 'h04000);
    erase('h30, 'h00000); poll(3, 'h00000);
    erase('h50, 'h03000); poll(3, 'h03000);
    erase('h10, 'h5555); poll(3, 'h04000);
    erase('h50, 'h04000); poll(TG + 1, 'h04000);
    cur_req = "R9"; cmd('h40); wr('h70000, 'h03);
    cmd('h90); rd('h00002); rd('h7FFF2); wr('h0, 'hF0);
    prog('h70000, 'h00); poll(TP + 1, 'h70000);
    // R9 top 64K lockout after reset
    @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    cur_req = "R1"; rd('h70000);
    cur_req = "R9"; cmd('h40); wr('h40000, 'h05); cmd('h40); wr('h7ABCD, 'h03);
    cur_req = "R11"; cmd('h90); rd('h7FFF2); rd('h00002); rd('h00000); wr('h0, 'hF0);
    cur_req = "R10"; prog('h70001, 'h00); poll(3, 'h70001);
    erase('h50, 'h7F000); poll(3, 'h7F000);
    prog('h6FFFF, 'h81); poll(TP + 1, 'h6FFFF); rd('h6FFFF); rd('h01000);
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule